// File: doc/BRIEF.md
# Warning-Driven Output Postscale Limiter

This block multiplies every channel's 24-bit signed audio sample by an 8-bit signed fractional gain just before the samples leave for the modulator. Normally the gain is the postscale byte. When the power stage flags trouble, the block switches to a second, lower byte, the limit byte, to pull the output level down. A typical limit byte is about 0.7 of full scale, which is roughly 3 dB of reduction.

The two warnings are treated differently. The overcurrent warning (active high) takes effect at once. The thermal warning (active low) must stay present for more than a programmable number of millisecond ticks before limiting begins. Its persistence count restarts whenever the thermal warning goes away. Limiting ends as soon as both warnings are clear.

While limiting, the block uses whichever of the two bytes is smaller as a signed number. Limiting therefore can never raise the gain. Both warnings pass through a short synchronizer chain, because they come from another domain.

Top module: `postscale_limiter`

## Requirements
- R1: During and right after synchronous reset, `out_valid`, `limit_active` and every output sample are zero.
- R2: For each accepted sample, the output is the signed product of the 24-bit sample and the 8-bit gain, with the gain widened to 24 bits by appending 16 zero bits on the right. The product keeps bits 46 down to 23, which is Q1.23 with truncation toward minus infinity. The result appears with `out_valid` exactly two clock cycles after `in_valid`.
- R3: A product that does not fit in 24 bits saturates. For example, sample 0x800000 times gain 0x80 gives 0x7FFFFF.
- R4: A thermal warning (`therm_warn_n` = 0) starts limiting only after more than `HOLD_MS` ticks of `ms_tick` have arrived while the synchronized warning is continuously asserted. Exactly `HOLD_MS` ticks does not start limiting.
- R5: Any deassertion of the thermal warning before it qualifies restarts the tick count from zero.
- R6: The overcurrent warning (`ocur_warn` = 1) starts limiting with no persistence delay. `limit_active` rises within `SYNC_STAGES`+2 cycles.
- R7: While `limit_active` is 1, the gain applied is the signed minimum of `post_scale` and `lim_scale`. A limit byte larger than the postscale byte leaves the output unchanged.
- R8: When both warnings clear, limiting stops within `SYNC_STAGES`+2 cycles and the postscale byte applies again.
- R9: Every channel scales its own sample slice, channel k occupying bits [24k+23:24k]. All channels use the same gain in the same cycle.
- R10: `out_valid` is 1 only for samples that were presented with `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| therm_warn_n | input | 1 | Thermal warning, active low |
| ocur_warn | input | 1 | Overcurrent warning, active high |
| post_scale | input | FACT_W | Normal postscale gain, signed Q1.7 |
| lim_scale | input | FACT_W | Gain used under warning, signed Q1.7 |
| in_valid | input | 1 | Input samples valid |
| in_samples | input | NCH*SAMP_W | Packed channel samples, signed Q1.23 |
| out_valid | output | 1 | Output samples valid |
| out_samples | output | NCH*SAMP_W | Scaled, saturated channel samples |
| limit_active | output | 1 | Limit gain selection in force |

## Verification
The bench builds the block with two channels, `HOLD_MS` = 5 and two synchronizer stages. The short hold count puts the thermal qualification boundary within a few dozen cycles. This means the bench can probe the tick exactly at the limit, and one tick past it, and can interrupt the warning part way through a count. The sample patterns cover both signs, full scale, and the single overflowing product. Two channels are enough to show that the slices do not leak into each other.

// File: rtl/plim_pkg.sv
package plim_pkg;
  localparam int SAMP_W_DEF  = 24;
  localparam int FACT_W_DEF  = 8;
  localparam int HOLD_MS_DEF = 400;

  typedef enum logic {
    SRC_POST = 1'b0,
    SRC_LIM  = 1'b1
  } gain_src_e;
endpackage

// File: rtl/plim_sync.sv
module plim_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/plim_persist.sv
module plim_persist #(
  parameter int HOLD_MS = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic warn,
  input  logic tick,
  output logic qualified
);
  localparam int CNT_W = $clog2(HOLD_MS + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_MS);

  logic [CNT_W-1:0] cnt;
  logic             past_limit;

  assign past_limit = (cnt > LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!warn) begin
      cnt <= '0;
    end else if (tick && !past_limit) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) qualified <= 1'b0;
    else     qualified <= warn && past_limit;
  end
endmodule

// File: rtl/plim_gain_sel.sv
module plim_gain_sel
  import plim_pkg::*;
#(
  parameter int FACT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              therm_q,
  input  logic              ocur_s,
  input  logic [FACT_W-1:0] post_scale,
  input  logic [FACT_W-1:0] lim_scale,
  output logic              limit_active,
  output logic [FACT_W-1:0] gain
);
  gain_src_e src;

  always_ff @(posedge clk) begin
    if (rst) limit_active <= 1'b0;
    else     limit_active <= therm_q | ocur_s;
  end

  always_comb begin
    src = SRC_POST;
    if (limit_active && ($signed(lim_scale) < $signed(post_scale))) src = SRC_LIM;
  end

  assign gain = (src == SRC_LIM) ? lim_scale : post_scale;
endmodule

// File: rtl/plim_chan_mult.sv
module plim_chan_mult #(
  parameter int SAMP_W = 24,
  parameter int FACT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [SAMP_W-1:0] sample,
  input  logic [FACT_W-1:0] gain,
  output logic [SAMP_W-1:0] result
);
  localparam int PAD_W  = SAMP_W - FACT_W;
  localparam int PROD_W = 2 * SAMP_W;
  localparam int KEEP_W = SAMP_W + 1;
  localparam logic [SAMP_W-1:0] POS_MAX = {1'b0, {(SAMP_W-1){1'b1}}};
  localparam logic [SAMP_W-1:0] NEG_MAX = {1'b1, {(SAMP_W-1){1'b0}}};

  logic signed [SAMP_W-1:0] gain_wide;
  logic signed [PROD_W-1:0] prod;
  logic [KEEP_W-1:0]        prod_hi;
  logic                     unused_low;

  assign gain_wide  = $signed({gain, {PAD_W{1'b0}}});
  assign prod       = $signed(sample) * gain_wide;
  assign unused_low = ^prod[SAMP_W-2:0];

  always_ff @(posedge clk) begin
    if (rst)     prod_hi <= '0;
    else if (en) prod_hi <= prod[PROD_W-1:SAMP_W-1];
  end

  logic overflow;
  assign overflow = prod_hi[KEEP_W-1] ^ prod_hi[KEEP_W-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (overflow) begin
      result <= prod_hi[KEEP_W-1] ? NEG_MAX : POS_MAX;
    end else begin
      result <= prod_hi[SAMP_W-1:0];
    end
  end
endmodule

// File: rtl/postscale_limiter.sv
module postscale_limiter
  import plim_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SAMP_W      = SAMP_W_DEF,
  parameter int FACT_W      = FACT_W_DEF,
  parameter int HOLD_MS     = HOLD_MS_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ms_tick,
  input  logic                  therm_warn_n,
  input  logic                  ocur_warn,
  input  logic [FACT_W-1:0]     post_scale,
  input  logic [FACT_W-1:0]     lim_scale,
  input  logic                  in_valid,
  input  logic [NCH*SAMP_W-1:0] in_samples,
  output logic                  out_valid,
  output logic [NCH*SAMP_W-1:0] out_samples,
  output logic                  limit_active
);
  localparam int PIPE = 2;

  logic therm_n_s;
  logic therm_s;
  logic ocur_s;
  logic therm_q;
  logic [FACT_W-1:0] gain;

  plim_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_therm (
    .clk(clk), .rst(rst), .d(therm_warn_n), .q(therm_n_s)
  );
  plim_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ocur (
    .clk(clk), .rst(rst), .d(ocur_warn), .q(ocur_s)
  );

  assign therm_s = ~therm_n_s;

  plim_persist #(.HOLD_MS(HOLD_MS)) u_persist (
    .clk(clk), .rst(rst), .warn(therm_s), .tick(ms_tick), .qualified(therm_q)
  );

  plim_gain_sel #(.FACT_W(FACT_W)) u_gain (
    .clk(clk), .rst(rst), .therm_q(therm_q), .ocur_s(ocur_s),
    .post_scale(post_scale), .lim_scale(lim_scale),
    .limit_active(limit_active), .gain(gain)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      plim_chan_mult #(.SAMP_W(SAMP_W), .FACT_W(FACT_W)) u_mult (
        .clk(clk), .rst(rst), .en(in_valid),
        .sample(in_samples[c*SAMP_W +: SAMP_W]),
        .gain(gain),
        .result(out_samples[c*SAMP_W +: SAMP_W])
      );
    end
  endgenerate

  logic [PIPE-1:0] vpipe;
  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[PIPE-2:0], in_valid};
  end
  assign out_valid = vpipe[PIPE-1];
endmodule

// File: rtl/postscale_limiter_chk.sv
module postscale_limiter_chk #(
  parameter int FACT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic              limit_active,
  input logic              therm_s,
  input logic              therm_q,
  input logic              ocur_s,
  input logic [FACT_W-1:0] post_scale,
  input logic [FACT_W-1:0] gain
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)           age <= 2'd0;
    else if (age != 3) age <= age + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 2)));

  p_persist_r4: assert property (@(posedge clk) disable iff (rst)
    ((age != 2'd0) && $rose(therm_q)) |-> $past(therm_s));

  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    ((age != 2'd0) && $past(!therm_s)) |-> !therm_q);

  p_ocur_r6: assert property (@(posedge clk) disable iff (rst)
    ((age != 2'd0) && $past(ocur_s)) |-> limit_active);

  p_no_gain_rise_r7: assert property (@(posedge clk) disable iff (rst)
    limit_active |-> ($signed(gain) <= $signed(post_scale)));

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    ((age != 2'd0) && $past(!therm_q && !ocur_s)) |-> !limit_active);
endmodule

bind postscale_limiter postscale_limiter_chk #(.FACT_W(FACT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .limit_active(limit_active), .therm_s(therm_s), .therm_q(therm_q),
  .ocur_s(ocur_s), .post_scale(post_scale), .gain(gain)
);

// File: tb/postscale_limiter_tb_top.sv
module postscale_limiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int SW  = 24;
  localparam int FW  = 8;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0;
  logic therm_warn_n = 1'b1;
  logic ocur_warn = 1'b0;
  logic [FW-1:0] post_scale = 8'h7F;
  logic [FW-1:0] lim_scale  = 8'h5A;
  logic in_valid = 1'b0;
  logic [NCH*SW-1:0] in_samples = '0;
  logic out_valid;
  logic [NCH*SW-1:0] out_samples;
  logic limit_active;

  always #(CLK_PERIOD/2) clk = ~clk;

  postscale_limiter #(.NCH(NCH), .SAMP_W(SW), .FACT_W(FW), .HOLD_MS(HOLD),
                      .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .therm_warn_n(therm_warn_n),
    .ocur_warn(ocur_warn), .post_scale(post_scale), .lim_scale(lim_scale),
    .in_valid(in_valid), .in_samples(in_samples), .out_valid(out_valid),
    .out_samples(out_samples), .limit_active(limit_active)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [NCH*SW-1:0] exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] ref_scale(input logic [SW-1:0] s,
                                              input logic [FW-1:0] f);
    longint p, r;
    p = longint'($signed(s)) * longint'($signed({f, 16'h0000}));
    r = p >>> 23;
    if (r > 64'sd8388607)   r = 64'sd8388607;
    if (r < -64'sd8388608)  r = -64'sd8388608;
    return r[SW-1:0];
  endfunction

  function automatic logic [FW-1:0] smin(input logic [FW-1:0] a, input logic [FW-1:0] b);
    return ($signed(a) < $signed(b)) ? a : b;
  endfunction

  task automatic send(input logic [SW-1:0] s0, input logic [SW-1:0] s1,
                      input logic [FW-1:0] f, input string tag);
    @(negedge clk);
    in_samples = {s1, s0};
    in_valid = 1'b1;
    exp_q.push_back({ref_scale(s1, f), ref_scale(s0, f)});
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_pulse();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
    idle(2);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected out_valid", 64'(out_samples), 64'h0);
      end else begin
        logic [NCH*SW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_samples == e, t, 64'(out_samples), 64'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 64'h0, 64'h1);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(out_valid == 0 && limit_active == 0 && out_samples == '0, "R1 reset state",
          64'({out_valid, limit_active}), 64'h0);
    @(negedge clk) rst = 1'b0;
    idle(2);
    check(out_valid == 0 && limit_active == 0 && out_samples == '0, "R1 after reset",
          64'({out_valid, limit_active}), 64'h0);

    // R2 / R9 normal scaling, several patterns
    send(24'h400000, 24'hC00000, 8'h7F, "R2 R9 half-scale both signs");
    send(24'h7FFFFF, 24'h000001, 8'h7F, "R2 R9 full scale and lsb");
    send(24'h123456, 24'hFEDCBA, 8'h7F, "R2 R9 mixed values");
    idle(4);
    post_scale = 8'h40;
    idle(1);
    send(24'h7FFFFF, 24'h800000, 8'h40, "R2 gain 0.5");
    idle(4);
    // R3 saturation
    post_scale = 8'h80;
    idle(1);
    send(24'h800000, 24'h400000, 8'h80, "R3 saturate -1*-1");
    idle(4);
    check(exp_q.size() == 0, "R10 no extra outputs", 64'(exp_q.size()), 64'h0);

    // R4 thermal persistence boundary
    post_scale = 8'h7F; lim_scale = 8'h5A;
    therm_warn_n = 1'b0;
    idle(4);
    repeat (HOLD) tick_pulse();
    idle(4);
    check(limit_active == 0, "R4 exactly HOLD ticks", 64'(limit_active), 64'h0);
    send(24'h200000, 24'hE00000, 8'h7F, "R4 still post gain");
    tick_pulse();
    idle(4);
    check(limit_active == 1, "R4 past HOLD ticks", 64'(limit_active), 64'h1);
    send(24'h200000, 24'hE00000, smin(8'h7F, 8'h5A), "R4 R7 limit gain");
    idle(4);

    // R8 release
    therm_warn_n = 1'b1;
    idle(4);
    check(limit_active == 0, "R8 release thermal", 64'(limit_active), 64'h0);
    send(24'h300000, 24'h100000, 8'h7F, "R8 post gain again");
    idle(4);

    // R5 restart of count
    therm_warn_n = 1'b0; idle(4);
    repeat (3) tick_pulse();
    therm_warn_n = 1'b1; idle(4);
    therm_warn_n = 1'b0; idle(4);
    repeat (3) tick_pulse();
    idle(4);
    check(limit_active == 0, "R5 count restarted", 64'(limit_active), 64'h0);
    repeat (3) tick_pulse();
    idle(4);
    check(limit_active == 1, "R5 requalified", 64'(limit_active), 64'h1);
    therm_warn_n = 1'b1; idle(5);

    // R6 overcurrent immediate, R7 limit above postscale
    post_scale = 8'h40; lim_scale = 8'h70;
    @(negedge clk) ocur_warn = 1'b1;
    idle(4);
    check(limit_active == 1, "R6 overcurrent immediate", 64'(limit_active), 64'h1);
    send(24'h7FFFFF, 24'h9ABCDE, 8'h40, "R7 larger limit ignored");
    idle(4);
    lim_scale = 8'h20;
    idle(1);
    send(24'h7FFFFF, 24'h9ABCDE, 8'h20, "R7 smaller limit used");
    idle(4);
    ocur_warn = 1'b0;
    idle(4);
    check(limit_active == 0, "R8 release overcurrent", 64'(limit_active), 64'h0);
    send(24'h7FFFFF, 24'h9ABCDE, 8'h40, "R8 R9 post restored");
    idle(6);
    check(exp_q.size() == 0, "R10 all outputs seen", 64'(exp_q.size()), 64'h0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule